// File: doc/BRIEF.md
# Dual-Edge Three-Port Register File

This block is the general-purpose register store of a small 32-bit load/store processor. It holds a set of word-wide registers and serves two independent read ports and one write port in every clock cycle. Each port is addressed by its own register index. Both read results are captured into output registers on the rising clock edge. A write with its enable high is committed to the array on the falling edge in the middle of the same cycle.

Because writes land half a cycle before the next rising edge, a value written in one cycle is returned by a read of the same index at the rising edge that closes that cycle. Write-back therefore needs no forwarding path. Register 0 is a constant zero. A synchronous active-high reset clears the array and both read outputs.

All ports are plain control and data pins with no valid/ready handshake. The block accepts a read pair and an optional write in every cycle and never applies back-pressure. The datapath must hold the indices, the write enable and the write data stable for the whole cycle, including the falling edge.

Top module: `dualedge_regfile`

## Requirements
- R1: The array holds 32 registers of 32 bits. After each rising edge, `rd_data_a` equals the register selected by `rd_idx_a` and `rd_data_b` equals the register selected by `rd_idx_b`. Each index is a 5-bit binary register number, and the two ports are independent.
- R2: When both read indices name the same register, both read outputs return the same value after the rising edge.
- R3: When `wr_en` is high, the register named by `wr_idx` takes `wr_data` at the falling edge of that cycle, and no other register changes.
- R4: When `wr_en` is low, no register changes, whatever `wr_idx` and `wr_data` carry.
- R5: Index 0 always reads as zero, and writes addressed to index 0 are discarded.
- R6: A write and a read of the same index in the same cycle return the newly written data on the rising edge that ends that cycle.
- R7: When `rst` is high in a cycle, both read outputs are zero after its rising edge and all registers are zero. A write requested in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Reads are captured on the rising edge; writes commit on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 5 | Register index for read port A |
| rd_idx_b | input | 5 | Register index for read port B |
| rd_data_a | output | 32 | Registered read result of port A |
| rd_data_b | output | 32 | Registered read result of port B |
| wr_en | input | 1 | Write enable for this cycle |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 32 | Shared write data bus |

## Verification
Each stimulus is applied just after a rising edge. A write in that stimulus commits at the following falling edge. Both read results of that stimulus become visible one rising edge after it is applied. The bench checks them one time unit after that edge, so a same-index write and read from one stimulus is compared in that same cycle. Reset, too, is applied for one cycle and compared at the edge that ends it. Before computing the expected read values, the reference model applies each write (or reset clear) in the order the falling edge imposes.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_NREGS = 32;
  localparam int unsigned RF_WIDTH = 32;
  localparam int unsigned RF_IDXW  = $clog2(RF_NREGS);
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS,
  parameter int unsigned IDXW  = rf_pkg::RF_IDXW
) (
  input  logic             en,
  input  logic [IDXW-1:0]  idx,
  output logic [NREGS-1:0] sel
);
  // one-hot select gated by the enable; slot 0 never selected
  for (genvar i = 0; i < NREGS; i++) begin : g_dec
    if (i == 0) begin : g_zero
      assign sel[i] = 1'b0;
    end else begin : g_line
      assign sel[i] = en && (idx == IDXW'(i));
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREGS-1:0]            sel,
  input  logic [WIDTH-1:0]            wdata,
  output logic [NREGS-1:0][WIDTH-1:0] cells
);
  // storage updates on the falling edge: half-cycle write-back slot
  for (genvar i = 0; i < NREGS; i++) begin : g_cell
    if (i == 0) begin : g_const
      assign cells[i] = '0;
    end else begin : g_ff
      logic [WIDTH-1:0] q;
      always_ff @(negedge clk) begin
        if (rst)         q <= '0;
        else if (sel[i]) q <= wdata;
      end
      assign cells[i] = q;
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  parameter int unsigned IDXW  = rf_pkg::RF_IDXW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDXW-1:0]             idx,
  input  logic [NREGS-1:0][WIDTH-1:0] cells,
  output logic [WIDTH-1:0]            data
);
  logic [WIDTH-1:0] pick;

  always_comb begin
    pick = '0;
    for (int unsigned k = 0; k < NREGS; k++) begin
      if (idx == IDXW'(k)) pick = cells[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= pick;
  end
endmodule

// File: rtl/dualedge_regfile.sv
module dualedge_regfile #(
  parameter int unsigned NREGS = rf_pkg::RF_NREGS,
  parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
  localparam int unsigned IDXW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] rd_idx_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data
);
  logic [NREGS-1:0]            wsel;
  logic [NREGS-1:0][WIDTH-1:0] cells;

  rf_wr_decode #(.NREGS(NREGS), .IDXW(IDXW)) u_dec (
    .en(wr_en), .idx(wr_idx), .sel(wsel)
  );

  rf_bank #(.NREGS(NREGS), .WIDTH(WIDTH)) u_bank (
    .clk(clk), .rst(rst), .sel(wsel), .wdata(wr_data), .cells(cells)
  );

  rf_rd_port #(.NREGS(NREGS), .WIDTH(WIDTH), .IDXW(IDXW)) u_rd_a (
    .clk(clk), .rst(rst), .idx(rd_idx_a), .cells(cells), .data(rd_data_a)
  );

  rf_rd_port #(.NREGS(NREGS), .WIDTH(WIDTH), .IDXW(IDXW)) u_rd_b (
    .clk(clk), .rst(rst), .idx(rd_idx_b), .cells(cells), .data(rd_data_b)
  );
endmodule

// File: rtl/dualedge_regfile_chk.sv
module dualedge_regfile_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned IDXW  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [IDXW-1:0]  rd_idx_a,
  input logic [IDXW-1:0]  rd_idx_b,
  input logic [WIDTH-1:0] rd_data_a,
  input logic [WIDTH-1:0] rd_data_b,
  input logic             wr_en,
  input logic [IDXW-1:0]  wr_idx,
  input logic [WIDTH-1:0] wr_data
);
  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_a == '0) |=> (rd_data_a == '0)); // R5
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_b == '0) |=> (rd_data_b == '0)); // R5
  AST_SAME_INDEX: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_a == rd_idx_b) |=> (rd_data_a == rd_data_b)); // R2
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && rd_idx_a == wr_idx) |=> (rd_data_a == $past(wr_data))); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0)); // R7
endmodule

bind dualedge_regfile dualedge_regfile_chk #(.WIDTH(WIDTH), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
  .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/dualedge_regfile_tb.sv
`timescale 1ns/1ps
module dualedge_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_idx_a, rd_idx_b, wr_idx;
  logic [31:0] rd_data_a, rd_data_b, wr_data;
  logic        wr_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  dualedge_regfile u_dut (
    .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [31:0] exp_read(input logic [4:0] i);
    return (i == 5'd0) ? 32'd0 : model[i];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then compare both ports after the closing rising edge
  task automatic cyc(input logic r, input logic e, input logic [4:0] wi,
                     input logic [31:0] wd, input logic [4:0] a, input logic [4:0] b,
                     input string tag);
    rst = r; wr_en = e; wr_idx = wi; wr_data = wd; rd_idx_a = a; rd_idx_b = b;
    @(posedge clk); #1;
    if (r) begin
      for (int k = 0; k < 32; k++) model[k] = 32'd0;
    end else if (e && wi != 5'd0) begin
      model[wi] = wd;
    end
    check({tag, " port A"}, rd_data_a, r ? 32'd0 : exp_read(a));
    check({tag, " port B"}, rd_data_b, r ? 32'd0 : exp_read(b));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 32; k++) model[k] = 32'd0;
    // R7: reset cycles, including a write that must be dropped
    cyc(1, 0, 5'd0, 32'd0, 5'd0, 5'd0, "R7 reset");
    cyc(1, 1, 5'd4, 32'hDEAD_BEEF, 5'd4, 5'd4, "R7 reset write dropped");
    cyc(0, 0, 5'd0, 32'd0, 5'd4, 5'd31, "R7 after reset");
    // R1/R3: fill two registers then read them on different ports
    cyc(0, 1, 5'd3, 32'h1111_2222, 5'd1, 5'd2, "R3 write r3");
    cyc(0, 1, 5'd17, 32'hA5A5_5A5A, 5'd3, 5'd0, "R3 write r17");
    cyc(0, 0, 5'd0, 32'd0, 5'd3, 5'd17, "R1 two registers");
    cyc(0, 0, 5'd0, 32'd0, 5'd17, 5'd3, "R1 swapped ports");
    // R2: same register on both ports
    cyc(0, 0, 5'd0, 32'd0, 5'd17, 5'd17, "R2 same index");
    // R4: enable low leaves register intact
    cyc(0, 0, 5'd3, 32'hFFFF_0000, 5'd3, 5'd3, "R4 write disabled");
    cyc(0, 0, 5'd0, 32'd0, 5'd3, 5'd17, "R4 after disabled write");
    // R5: index 0 write discarded
    cyc(0, 1, 5'd0, 32'hCAFE_F00D, 5'd0, 5'd0, "R5 write zero");
    cyc(0, 0, 5'd0, 32'd0, 5'd0, 5'd3, "R5 zero reads zero");
    // R6: write and read same index in one cycle, then back-to-back overwrite
    cyc(0, 1, 5'd9, 32'h0BAD_C0DE, 5'd9, 5'd9, "R6 same cycle");
    cyc(0, 1, 5'd9, 32'h1234_5678, 5'd9, 5'd3, "R6 overwrite");
    cyc(0, 1, 5'd31, 32'h8000_0001, 5'd30, 5'd31, "R6 top index");
    // R1/R3/R4/R5/R6: constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic e; logic [4:0] wi, a, b; logic [31:0] wd;
      e  = ($urandom % 3) != 0;
      wi = 5'($urandom % 32);
      wd = $urandom;
      a  = (($urandom % 4) == 0) ? wi : 5'($urandom % 32);
      b  = (($urandom % 5) == 0) ? a  : 5'($urandom % 32);
      cyc(0, e, wi, wd, a, b, "R1 random");
    end
    // R7: reset mid-run clears written registers
    cyc(1, 1, 5'd12, 32'h7777_7777, 5'd9, 5'd31, "R7 mid-run reset");
    cyc(0, 0, 5'd0, 32'd0, 5'd9, 5'd12, "R7 cleared");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule